// File: doc/BRIEF.md
# Single-Clock FIFO with Programmable Thresholds and Rewind

This block is a first-in first-out buffer that runs on one clock. Words go in through a write enable and come out through a read enable. Besides the empty and full flags, it drives two threshold flags. One is an active-low "nearly empty" flag. The other is an active-low "nearly full" flag. Each threshold is held in an offset register. The two offset registers are loaded from a one-bit serial port that shifts on the block clock.

The output side runs in one of two modes, chosen once while the master reset is applied:

- **Standard mode:** a read request returns the head word one cycle later.
- **Fall-through mode:** the head word is presented on the output without any request.

A partial reset empties the buffer and keeps the chosen mode and the offset values.

A rewind input moves the read pointer back to word zero, or to a position recorded earlier with the mark input, so that a frame can be sent again. The rewind leaves the write side untouched. The rewind is meant for frames of at most DEPTH words counted from the rewind target, with no overwrite in between. After a master or partial reset, a rewind to zero is valid while at most DEPTH words have been written.

Top module: `pf_fifo`

## Requirements
- R1: After master reset the outputs are as follows: `empty`=1, `full`=0, `ae_n`=0 and `af_n`=1. Both offsets equal DEPTH/8, and no mark is held.
- R2: In standard mode a read accepted at a clock edge puts the oldest stored word on `rd_data` at that same edge. Words leave in the order they were written. `rd_data` holds its value when no read is accepted.
- R3: `full`=1 exactly when DEPTH words are stored. A write while full is dropped, and the stored words and the count do not change.
- R4: `empty`=1 exactly when no word is stored. A read while empty is dropped: `rd_data` and the count do not change.
- R5: `ae_n` is 0 while the stored word count is below the empty offset, and 1 when the count is greater than or equal to the empty offset.
- R6: `af_n` is 1 while the free locations (DEPTH minus count) are more than the full offset, and 0 when the free locations are equal to or fewer than the full offset.
- R7: Each clock edge with `ser_en`=1 shifts `ser_din` into the offset chain. Over 2·log2(DEPTH) edges the bits fill the empty offset first and then the full offset, least significant bit first. Each new value applies to the flags from the following cycle.
- R8: `part_rst`=1 at an edge empties the buffer: `empty`=1 and `rd_data`=0. It also clears the mark. The read mode and both offsets are kept.
- R9: `retx`=1 at an edge moves the read pointer to the mark, or to word zero if no mark is held. The count becomes the words from that point to the write pointer, and `empty` goes to 0. Writes in that cycle are still taken, reads are not, and the write pointer is not moved by the rewind.
- R10: A read accepted with `mark`=1 records the position of the word being read. A later rewind returns reading to that word.
- R11: In fall-through mode the head word is on `rd_data` whenever `empty`=0. The first word written into an empty buffer is on `rd_data`, with `empty`=0, right after its write edge, and no read is needed. A read advances to the next word.
- R12: The read mode is taken from `fwft_sel` (1 selects fall-through) while master reset is applied. Later changes on `fwft_sel` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| fwft_sel | input | 1 | Read mode select, sampled during master reset |
| part_rst | input | 1 | Partial reset, synchronous, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Write word |
| rd_en | input | 1 | Read request (standard) / advance (fall-through) |
| rd_data | output | WIDTH | Output register |
| mark | input | 1 | Record read position on an accepted read |
| retx | input | 1 | Rewind read pointer |
| ser_en | input | 1 | Serial offset shift enable |
| ser_din | input | 1 | Serial offset data bit |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |
| ae_n | output | 1 | Low while count is below the empty offset |
| af_n | output | 1 | Low while free locations are at most the full offset |

## Verification
The bench builds the block with DEPTH=16 and WIDTH=8. With these values the offsets are 4 bits wide and an 8-bit serial load covers both of them. The default offset is 2, so every threshold edge, the full condition and a dropped write all occur within a few dozen cycles. Both read modes are run through one instance by applying master reset twice with different `fwft_sel` values, and partial resets keep every rewind inside the DEPTH-word window.

// File: rtl/pf_fifo_pkg.sv
package pf_fifo_pkg;
  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/pf_fifo_store.sv
module pf_fifo_store #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/pf_fifo_offsets.sv
module pf_fifo_offsets #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = 2 * AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_en,
  input  logic          ser_din,
  output logic [AW-1:0] off_lo,
  output logic [AW-1:0] off_hi
);
  localparam logic [AW-1:0] OFF_DEF = AW'(DEPTH / 8);

  logic [CW-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = chain_q;
    if (ser_en) begin
      chain_d = {ser_din, chain_q[CW-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {OFF_DEF, OFF_DEF};
    end else if (ser_en) begin
      chain_q <= chain_d;
    end
  end

  assign off_lo = chain_q[AW-1:0];
  assign off_hi = chain_q[CW-1:AW];
endmodule

// File: rtl/pf_fifo_ctrl.sv
module pf_fifo_ctrl
  import pf_fifo_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rd_mode_e         mode,
  input  logic             part_rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             mark,
  input  logic             retx,
  input  logic [WIDTH-1:0] mem_rdata,
  output logic             mem_we,
  output logic [AW-1:0]    mem_waddr,
  output logic [AW-1:0]    mem_raddr,
  output logic [PW-1:0]    count,
  output logic [WIDTH-1:0] dout
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [PW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d, mark_q, mark_d, target;
  logic [PW-1:0]    count_q, count_d;
  logic             mark_vld_q, mark_vld_d;
  logic [WIDTH-1:0] dout_q, dout_d;
  logic             is_full, is_empty, wr_ok, rd_ok, bypass;

  always_comb begin
    is_full  = (count_q == DEPTH_P);
    is_empty = (count_q == '0);
    wr_ok    = wr_en && !is_full && !part_rst;
    rd_ok    = rd_en && !is_empty && !retx && !part_rst;
    target   = mark_vld_q ? mark_q : '0;

    wptr_d = part_rst ? '0 : wptr_q + PW'(wr_ok);
    if (part_rst) begin
      rptr_d = '0;
    end else if (retx) begin
      rptr_d = target;
    end else begin
      rptr_d = rptr_q + PW'(rd_ok);
    end
    count_d = wptr_d - rptr_d;

    mark_d     = mark_q;
    mark_vld_d = mark_vld_q;
    if (part_rst) begin
      mark_d     = '0;
      mark_vld_d = 1'b0;
    end else if (rd_ok && mark) begin
      mark_d     = rptr_q;
      mark_vld_d = 1'b1;
    end

    mem_raddr = (mode == RD_FWFT) ? rptr_d[AW-1:0] : rptr_q[AW-1:0];
    bypass    = wr_ok && (wptr_q[AW-1:0] == rptr_d[AW-1:0]);

    dout_d = dout_q;
    if (part_rst) begin
      dout_d = '0;
    end else if (mode == RD_STD) begin
      if (rd_ok) begin
        dout_d = mem_rdata;
      end
    end else if (count_d != '0) begin
      dout_d = bypass ? wr_data : mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q     <= '0;
      rptr_q     <= '0;
      count_q    <= '0;
      mark_q     <= '0;
      mark_vld_q <= 1'b0;
      dout_q     <= '0;
    end else begin
      wptr_q     <= wptr_d;
      rptr_q     <= rptr_d;
      count_q    <= count_d;
      mark_q     <= mark_d;
      mark_vld_q <= mark_vld_d;
      dout_q     <= dout_d;
    end
  end

  assign mem_we    = wr_ok;
  assign mem_waddr = wptr_q[AW-1:0];
  assign count     = count_q;
  assign dout      = dout_q;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= DEPTH_P);
  assert_full_drops_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == DEPTH_P) && wr_en && !part_rst |=> $stable(wptr_q));
  assert_empty_drops_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0) && rd_en && !retx && !part_rst |=> $stable(rptr_q));
  assert_part_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    part_rst |=> (count_q == '0) && (dout_q == '0) && !mark_vld_q);
  assert_rewind_keeps_wptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retx && !wr_en && !part_rst |=> $stable(wptr_q));
endmodule

// File: rtl/pf_fifo.sv
module pf_fifo
  import pf_fifo_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fwft_sel,
  input  logic             part_rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic             mark,
  input  logic             retx,
  input  logic             ser_en,
  input  logic             ser_din,
  output logic             empty,
  output logic             full,
  output logic             ae_n,
  output logic             af_n
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  rd_mode_e         mode_q;
  logic             mem_we;
  logic [AW-1:0]    mem_waddr, mem_raddr;
  logic [WIDTH-1:0] mem_rdata;
  logic [PW-1:0]    count;
  logic [AW-1:0]    off_lo, off_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  always_ff @(posedge clk) begin
    if (!rst_core_n) begin
      mode_q <= fwft_sel ? RD_FWFT : RD_STD;
    end
  end

  pf_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (wr_data),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  pf_fifo_offsets #(.DEPTH(DEPTH)) u_offsets (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .ser_en  (ser_en),
    .ser_din (ser_din),
    .off_lo  (off_lo),
    .off_hi  (off_hi)
  );

  pf_fifo_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .mode      (mode_q),
    .part_rst  (part_rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .mark      (mark),
    .retx      (retx),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_raddr (mem_raddr),
    .count     (count),
    .dout      (rd_data)
  );

  assign empty = (count == '0);
  assign full  = (count == DEPTH_P);
  assign ae_n  = (count >= {1'b0, off_lo});
  assign af_n  = ((DEPTH_P - count) > {1'b0, off_hi});

  assert_mode_locked_R12: assert property (@(posedge clk) disable iff (!rst_core_n)
    $stable(mode_q));
  assert_part_keeps_offsets_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    part_rst && !ser_en |=> $stable({off_lo, off_hi}));
  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(empty && full));
endmodule

// File: tb/pf_fifo_bench.sv
module pf_fifo_bench;
  localparam int W = 8;
  localparam int D = 16;

  logic clk, rst_n, fwft_sel, part_rst, wr_en, rd_en, mark, retx, ser_en, ser_din;
  logic [W-1:0] wr_data, rd_data;
  logic empty, full, ae_n, af_n;

  pf_fifo #(.WIDTH(W), .DEPTH(D)) u_pf_fifo (
    .clk(clk), .rst_n(rst_n), .fwft_sel(fwft_sel), .part_rst(part_rst),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .mark(mark), .retx(retx), .ser_en(ser_en), .ser_din(ser_din),
    .empty(empty), .full(full), .ae_n(ae_n), .af_n(af_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  logic [W-1:0] hist [64];
  logic [W-1:0] exp_q [$];
  int wcount = 0, ridx = 0, mcnt = 0, mark_idx = 0;
  bit mark_v = 0, fwft_m = 0, std_pend = 0, done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    wcount = 0; ridx = 0; mcnt = 0; mark_v = 0; mark_idx = 0;
    exp_q.delete(); std_pend = 0;
  endtask

  task automatic zero_in();
    wr_en = 0; wr_data = '0; rd_en = 0; mark = 0; retx = 0;
    part_rst = 0; ser_en = 0; ser_din = 0;
  endtask

  // driver: one clock edge of stimulus, pushes expected words into the queue
  task automatic cyc(input bit w, input logic [W-1:0] d, input bit r,
                     input bit mk, input bit rt, input bit pr);
    bit wok, rok;
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r; mark = mk; retx = rt; part_rst = pr;
    ser_en = 0;
    @(posedge clk);
    if (pr) begin
      clear_model();
    end else begin
      wok = w && (mcnt < D);
      rok = r && (mcnt > 0) && !rt;
      if (rok && mk) begin mark_idx = ridx; mark_v = 1; end
      if (wok) begin hist[wcount] = d; wcount++; exp_q.push_back(d); end
      if (rt) begin
        ridx = mark_v ? mark_idx : 0;
        exp_q.delete();
        for (int i = ridx; i < wcount; i++) exp_q.push_back(hist[i]);
      end else if (rok) begin
        ridx++;
        if (fwft_m) void'(exp_q.pop_front());
        else std_pend = 1;
      end
      mcnt = wcount - ridx;
    end
  endtask

  task automatic wr(input logic [W-1:0] d); cyc(1, d, 0, 0, 0, 0); endtask
  task automatic rd(); cyc(0, '0, 1, 0, 0, 0); endtask

  task automatic ser_bit(input bit b);
    @(negedge clk);
    zero_in(); ser_en = 1; ser_din = b;
    @(posedge clk);
  endtask

  task automatic look();
    @(negedge clk);
    zero_in();
  endtask

  task automatic mreset(input bit f);
    @(negedge clk);
    zero_in(); fwft_sel = f; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    clear_model(); fwft_m = f;
  endtask

  // monitor: compares the output register with the queue head
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!fwft_m && std_pend) begin
        std_pend = 0;
        if (exp_q.size() > 0) chk("R2 std read data", int'(rd_data), int'(exp_q.pop_front()));
      end else if (fwft_m && mcnt > 0 && exp_q.size() > 0) begin
        chk("R11 fall-through head", int'(rd_data), int'(exp_q[0]));
        chk("R11 not empty with head", int'(empty), 0);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1; fwft_sel = 0; zero_in();
    #1 rst_n = 0;
    mreset(0);
    // R1 reset state
    chk("R1 empty", int'(empty), 1); chk("R1 full", int'(full), 0);
    chk("R1 ae_n", int'(ae_n), 0);   chk("R1 af_n", int'(af_n), 1);

    // R2 order
    wr(8'hA0); wr(8'hA1); wr(8'hA2);
    rd(); rd(); rd();
    look(); chk("R2 empty after drain", int'(empty), 1);

    // R4 read while empty
    rd(); look();
    chk("R4 data held", int'(rd_data), 8'hA2);
    chk("R4 still empty", int'(empty), 1);

    // R5/R6/R3 thresholds and full with default offsets of 2
    wr(8'h10); look(); chk("R5 count1 ae_n", int'(ae_n), 0);
    wr(8'h11); look(); chk("R5 count2 ae_n", int'(ae_n), 1);
    for (int i = 2; i < 13; i++) wr(8'h10 + 8'(i));
    look(); chk("R6 free3 af_n", int'(af_n), 1);
    wr(8'h1D); look(); chk("R6 free2 af_n", int'(af_n), 0);
    wr(8'h1E); wr(8'h1F); look();
    chk("R3 full at depth", int'(full), 1);
    wr(8'hEE); look();
    chk("R3 still full after dropped write", int'(full), 1);
    for (int i = 0; i < 16; i++) rd();
    look(); chk("R3 drained, no extra word", int'(empty), 1);

    // R7 serial load: empty offset 5, full offset 4, LSB first
    ser_bit(1); ser_bit(0); ser_bit(1); ser_bit(0);
    ser_bit(0); ser_bit(0); ser_bit(1); ser_bit(0);
    // R8 partial reset keeps offsets
    cyc(0, '0, 0, 0, 0, 1); look();
    chk("R8 empty after partial", int'(empty), 1);
    chk("R8 output zeroed", int'(rd_data), 0);
    for (int i = 0; i < 4; i++) wr(8'h30 + 8'(i));
    look(); chk("R7 count4 ae_n", int'(ae_n), 0);
    wr(8'h34); look(); chk("R7 count5 ae_n (R8 kept)", int'(ae_n), 1);
    for (int i = 5; i < 11; i++) wr(8'h30 + 8'(i));
    look(); chk("R7 free5 af_n", int'(af_n), 1);
    wr(8'h3B); look(); chk("R7 free4 af_n", int'(af_n), 0);

    // R9 rewind to zero
    cyc(0, '0, 0, 0, 0, 1);
    for (int i = 0; i < 4; i++) wr(8'h40 + 8'(i));
    for (int i = 0; i < 4; i++) rd();
    look(); chk("R9 empty before rewind", int'(empty), 1);
    cyc(0, '0, 0, 0, 1, 0); look();
    chk("R9 empty low after rewind", int'(empty), 0);
    for (int i = 0; i < 4; i++) rd();
    look(); chk("R9 empty after replay", int'(empty), 1);

    // R10 mark then rewind
    cyc(0, '0, 0, 0, 0, 1);
    for (int i = 0; i < 6; i++) wr(8'h50 + 8'(i));
    rd(); rd(); cyc(0, '0, 1, 1, 0, 0); rd();
    cyc(0, '0, 0, 0, 1, 0);
    rd(); look();
    chk("R10 rewind to marked word", int'(rd_data), 8'h52);
    rd(); rd(); rd(); look();
    chk("R10 empty after marked replay", int'(empty), 1);

    // R11/R12 fall-through mode
    mreset(1);
    fwft_sel = 0;
    chk("R1 empty after second reset", int'(empty), 1);
    wr(8'h60); look();
    chk("R11 first word without read", int'(rd_data), 8'h60);
    chk("R11 empty low after first write", int'(empty), 0);
    chk("R1 offset default count1", int'(ae_n), 0);
    wr(8'h61); wr(8'h62); look();
    chk("R1 offset default count3", int'(ae_n), 1);
    rd(); look(); chk("R11 advance", int'(rd_data), 8'h61);
    rd(); rd(); look(); chk("R11 empty after drain", int'(empty), 1);
    wr(8'h63); look();
    chk("R12 mode kept despite select change", int'(rd_data), 8'h63);

    // R8/R9 in fall-through mode
    cyc(0, '0, 0, 0, 0, 1); look();
    chk("R8 fall-through output zeroed", int'(rd_data), 0);
    wr(8'h70); wr(8'h71); wr(8'h72);
    rd(); rd(); rd(); look();
    chk("R9 fall-through empty", int'(empty), 1);
    cyc(0, '0, 0, 0, 1, 0); look();
    chk("R9 fall-through rewind empty", int'(empty), 0);
    chk("R9 fall-through rewind head", int'(rd_data), 8'h70);

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule